// File: doc/BRIEF.md
# Configurable Secondary Scan Chain Linker

This block sits behind one primary test access port and joins up to three secondary scan chains into a single serial path. An active-low configuration word chooses which secondary chains take part. A two-bit position strap says whether the device stands alone or is the first, a middle or the last member of a cascade of such linkers. Cascaded linkers hand the serial stream from one to the next through a cascade input and a cascade output.

The block drives the mode-select line of every included chain from the primary mode select. An excluded chain keeps the mode-select level it last saw, and its data output is released. Every secondary clock follows the primary clock, and every secondary reset is held inactive.

Flip-flops are placed along the internal serial path so that the path never has a long combinational run when linkers are cascaded. These flops add bits to the scan length, and the test program must count them. They move only while the primary controller reports a shift state. A new configuration is taken up only on a clock edge where the primary controller is in its idle state, so the path never changes during a shift. All serial pins are plain levels sampled on the primary clock. There is no handshake: a bit moves on every rising clock edge that has the shift input high.

Top module: `jtag_chain_linker`

## Requirements
- R1: Configuration bit i is active-low. Bit i low includes secondary chain i, and the output enable `sec_tdo_oe[i]` of an included chain is high.
- R2: Included chains are joined in ascending index order. The first included chain receives the path input, and each later included chain receives the return of the previous included chain. Chain i's `sec_tdo` carries the path-input bit delayed by 1 + the sum of (length+1) over the included chains below i.
- R3: An excluded chain has its output enable `sec_tdo_oe[i]` low, which means its data line is high-impedance.
- R4: An included chain's `sec_tms` equals the primary `tms`. An excluded chain's `sec_tms` stays at the `tms` level that was sampled on the clock edge at which it became excluded.
- R5: `sec_tck` equals `tck` on every chain, and `sec_trst_n` is always high.
- R6: Position code 0 (single) and code 1 (first) take the path input from `tdi`. Code 2 (middle) and code 3 (last) take it from `chain_in`.
- R7: Codes 0 and 3 drive the path output on `tdo` with `tdo_oe` high and `chain_out_oe` low. Codes 1 and 2 drive it on `chain_out` with `chain_out_oe` high and `tdo_oe` low. With no chain included, the path output is the input pad.
- R8: One pad flop sits at the path input, and one pad flop sits on each included chain's return. That gives 1 to 4 pad bits, and a total path length of 1 + the sum of (length+1) over the included chains.
- R9: Pad flops capture on the rising edge of `tck` only while `shift_en` is high, and hold otherwise.
- R10: `cfg_n` is taken up only at a rising `tck` edge with `rti` high. After reset every chain is excluded, with `sec_tms` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Primary test clock |
| trst_n | input | 1 | Primary test reset, active low, asynchronous |
| tms | input | 1 | Primary mode select |
| tdi | input | 1 | Primary serial data in |
| tdo | output | 1 | Primary serial data out |
| tdo_oe | output | 1 | Drive enable for tdo |
| shift_en | input | 1 | Primary controller is in a shift state |
| rti | input | 1 | Primary controller is in Run-Test/Idle |
| cfg_n | input | NCH | Active-low chain include bits |
| pos | input | 2 | Cascade position: 0 single, 1 first, 2 middle, 3 last |
| chain_in | input | 1 | Serial input from the previous linker |
| chain_out | output | 1 | Serial output to the next linker |
| chain_out_oe | output | 1 | Drive enable for chain_out |
| sec_tck | output | NCH | Secondary clocks |
| sec_trst_n | output | NCH | Secondary resets, held high |
| sec_tms | output | NCH | Secondary mode selects |
| sec_tdo | output | NCH | Serial data to each secondary chain |
| sec_tdo_oe | output | NCH | Drive enable per sec_tdo |
| sec_tdi | input | NCH | Serial return from each secondary chain |

## Verification
The hardest case to reach from the ports is the frozen mode-select level. A chain must first be included. Then, on one idle-state edge, the bench must remove it from the path while `tms` holds a chosen value, and afterwards drive the opposite value. The stimulus does this with a directed sequence in which the exclusion edge carries `tms` low and later cycles carry it high. The ascending join order is also hidden inside the path. The bench exposes it by comparing each included chain's `sec_tdo` against the random input pattern, delayed by the computed prefix length. It does this for all eight configurations at all four positions.

// File: rtl/jl_pkg.sv
package jl_pkg;
  typedef enum logic [1:0] {
    POS_SINGLE = 2'd0,
    POS_FIRST  = 2'd1,
    POS_MIDDLE = 2'd2,
    POS_LAST   = 2'd3
  } pos_e;
endpackage

// File: rtl/jl_pad.sv
// One pad bit of the serial path; moves only during shift.
module jl_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/jl_cfg_latch.sv
// Active configuration, updated only at idle-state edges.
module jl_cfg_latch #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NCH-1:0] cfg_n,
  output logic [NCH-1:0] inc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    inc <= '0;
    else if (load) inc <= ~cfg_n;
  end
endmodule

// File: rtl/jl_tms_hold.sv
// Per-chain mode select: follows primary while included, frozen otherwise.
module jl_tms_hold #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tms,
  input  logic [NCH-1:0] inc,
  output logic [NCH-1:0] sec_tms
);
  logic [NCH-1:0] held_q;

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q[i] <= 1'b1;
      else if (inc[i]) held_q[i] <= tms;
    end
    assign sec_tms[i] = inc[i] ? tms : held_q[i];
  end
endmodule

// File: rtl/jl_route.sv
// Joins included chains in ascending order behind the input pad.
module jl_route #(
  parameter int NCH = 3
) (
  input  logic           in_q,
  input  logic [NCH-1:0] ret_q,
  input  logic [NCH-1:0] inc,
  output logic [NCH-1:0] sec_tdo,
  output logic [NCH-1:0] sec_tdo_oe,
  output logic           path_out
);
  logic cur;

  always_comb begin
    cur = in_q;
    for (int i = 0; i < NCH; i++) begin
      sec_tdo[i]    = cur;
      sec_tdo_oe[i] = inc[i];
      if (inc[i]) cur = ret_q[i];
    end
    path_out = cur;
  end
endmodule

// File: rtl/jtag_chain_linker.sv
module jtag_chain_linker #(
  parameter int NCH = 3
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tms,
  input  logic           tdi,
  output logic           tdo,
  output logic           tdo_oe,
  input  logic           shift_en,
  input  logic           rti,
  input  logic [NCH-1:0] cfg_n,
  input  logic [1:0]     pos,
  input  logic           chain_in,
  output logic           chain_out,
  output logic           chain_out_oe,
  output logic [NCH-1:0] sec_tck,
  output logic [NCH-1:0] sec_trst_n,
  output logic [NCH-1:0] sec_tms,
  output logic [NCH-1:0] sec_tdo,
  output logic [NCH-1:0] sec_tdo_oe,
  input  logic [NCH-1:0] sec_tdi
);
  import jl_pkg::*;

  pos_e           pos_q;
  logic [NCH-1:0] inc;
  logic           path_in;
  logic           in_q;
  logic [NCH-1:0] ret_q;
  logic           path_out;
  logic           at_end;

  assign pos_q   = pos_e'(pos);
  assign path_in = (pos_q == POS_SINGLE || pos_q == POS_FIRST) ? tdi : chain_in;
  assign at_end  = (pos_q == POS_SINGLE || pos_q == POS_LAST);

  assign sec_tck    = {NCH{tck}};
  assign sec_trst_n = '1;

  jl_cfg_latch #(.NCH(NCH)) u_cfg (
    .clk(tck), .rst_n(trst_n), .load(rti), .cfg_n(cfg_n), .inc(inc)
  );

  jl_tms_hold #(.NCH(NCH)) u_tms (
    .clk(tck), .rst_n(trst_n), .tms(tms), .inc(inc), .sec_tms(sec_tms)
  );

  jl_pad u_in_pad (
    .clk(tck), .rst_n(trst_n), .en(shift_en), .d(path_in), .q(in_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ret
    jl_pad u_ret_pad (
      .clk(tck), .rst_n(trst_n), .en(shift_en), .d(sec_tdi[i]), .q(ret_q[i])
    );
  end

  jl_route #(.NCH(NCH)) u_route (
    .in_q(in_q), .ret_q(ret_q), .inc(inc),
    .sec_tdo(sec_tdo), .sec_tdo_oe(sec_tdo_oe), .path_out(path_out)
  );

  assign tdo          = path_out;
  assign chain_out    = path_out;
  assign tdo_oe       = at_end;
  assign chain_out_oe = !at_end;
endmodule

// File: rtl/jl_chk.sv
module jl_chk #(
  parameter int NCH = 3
) (
  input logic           tck,
  input logic           trst_n,
  input logic           tms,
  input logic           shift_en,
  input logic           rti,
  input logic           tdo,
  input logic           tdo_oe,
  input logic           chain_out_oe,
  input logic [NCH-1:0] sec_trst_n,
  input logic [NCH-1:0] sec_tms,
  input logic [NCH-1:0] sec_tdo_oe
);
  // R5
  trst_high_chk: assert property (@(posedge tck) disable iff (!trst_n)
    sec_trst_n == {NCH{1'b1}});

  // R7
  one_driver_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot({tdo_oe, chain_out_oe}));

  // R10
  cfg_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$past(rti) |-> $stable(sec_tdo_oe));

  // R9
  pad_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!$past(shift_en) && !$past(rti)) |-> $stable(tdo));

  for (genvar i = 0; i < NCH; i++) begin : g_tms
    // R4
    tms_frozen_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!sec_tdo_oe[i] && $past(!sec_tdo_oe[i])) |-> $stable(sec_tms[i]));
    // R4
    tms_follow_chk: assert property (@(negedge tck) disable iff (!trst_n)
      sec_tdo_oe[i] |-> (sec_tms[i] == tms));
  end
endmodule

bind jtag_chain_linker jl_chk #(.NCH(NCH)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .shift_en(shift_en), .rti(rti),
  .tdo(tdo), .tdo_oe(tdo_oe), .chain_out_oe(chain_out_oe),
  .sec_trst_n(sec_trst_n), .sec_tms(sec_tms), .sec_tdo_oe(sec_tdo_oe)
);

// File: tb/sim_jtag_chain_linker.sv
module sim_jtag_chain_linker;
  localparam int NCH = 3;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1, tdi = 1'b0, shift_en = 1'b0, rti = 1'b0, chain_in = 1'b0;
  logic [NCH-1:0] cfg_n = '0;
  logic [1:0] pos = 2'd0;
  logic tdo, tdo_oe, chain_out, chain_out_oe;
  logic [NCH-1:0] sec_tck, sec_trst_n, sec_tms, sec_tdo, sec_tdo_oe, sec_tdi;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  logic hist [0:63];

  always #10 tck = ~tck;

  jtag_chain_linker #(.NCH(NCH)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .shift_en(shift_en), .rti(rti), .cfg_n(cfg_n), .pos(pos), .chain_in(chain_in),
    .chain_out(chain_out), .chain_out_oe(chain_out_oe), .sec_tck(sec_tck),
    .sec_trst_n(sec_trst_n), .sec_tms(sec_tms), .sec_tdo(sec_tdo),
    .sec_tdo_oe(sec_tdo_oe), .sec_tdi(sec_tdi)
  );

  function automatic int clen(int i);
    return (i == 0) ? 3 : (i == 1) ? 4 : 6;
  endfunction

  // behavioural secondary chains of lengths 3, 4, 6
  for (genvar i = 0; i < NCH; i++) begin : g_sec
    logic [7:0] sr = '0;
    always @(posedge tck) if (shift_en && sec_tdo_oe[i]) sr <= {sr[6:0], sec_tdo[i]};
    assign sec_tdi[i] = sr[clen(i)-1];
  end

  function automatic int prefix_len(logic [2:0] c, int upto);
    int n = 1;
    for (int j = 0; j < upto; j++) if (!c[j]) n += clen(j) + 1;
    return n;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
  endtask

  always @(posedge tck) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      report();
      $finish;
    end
  end

  task automatic run_combo(input int p, input logic [2:0] c);
    int len, mis, omis, tmis;
    logic b, outv;
    pos = p[1:0]; cfg_n = c; rti = 1'b1; shift_en = 1'b0;
    tick();
    rti = 1'b0;
    chk(sec_tdo_oe == ~c, "R1 R3 include enables", sec_tdo_oe, ~c);
    len = prefix_len(c, NCH);
    mis = 0; omis = 0; tmis = 0;
    for (int e = 0; e < len + 16; e++) begin
      b = 1'($urandom);
      hist[e] = b;
      if (p >= 2) begin chain_in = b; tdi = 1'($urandom); end
      else        begin tdi = b; chain_in = 1'($urandom); end
      tms = 1'($urandom);
      shift_en = 1'b1;
      tick();
      outv = (p == 0 || p == 3) ? tdo : chain_out;
      if (e >= len - 1 && outv !== hist[e-len+1]) mis++;
      for (int i = 0; i < NCH; i++) begin
        if (!c[i]) begin
          int pf = prefix_len(c, i);
          if (e >= pf - 1 && sec_tdo[i] !== hist[e-pf+1]) omis++;
          if (sec_tms[i] !== tms) tmis++;
        end
      end
    end
    shift_en = 1'b0;
    chk(mis == 0, $sformatf("R6 R8 path length/source pos=%0d cfg=%0d", p, c), mis, 0);
    chk(omis == 0, $sformatf("R2 chain order pos=%0d cfg=%0d", p, c), omis, 0);
    chk(tmis == 0, "R4 included tms follows", tmis, 0);
    chk({tdo_oe, chain_out_oe} == ((p == 0 || p == 3) ? 2'b10 : 2'b01),
        "R7 output port select", {tdo_oe, chain_out_oe}, (p == 0 || p == 3) ? 2 : 1);
  endtask

  initial begin
    logic held;
    void'($urandom(32'd2718));
    cfg_n = 3'b000;
    repeat (3) @(negedge tck);
    chk(sec_tdo_oe == 3'b000, "R10 reset excludes all", sec_tdo_oe, 0);
    chk(sec_tms == 3'b111, "R10 reset tms high", sec_tms, 7);
    trst_n = 1'b1;
    tick();
    chk(sec_tdo_oe == 3'b000, "R10 no load without rti", sec_tdo_oe, 0);

    // R5 clocks and resets
    chk(sec_tck == 3'b000 && sec_trst_n == 3'b111, "R5 low phase", {sec_tck, sec_trst_n}, 7);
    @(posedge tck); #5;
    chk(sec_tck == 3'b111, "R5 high phase", sec_tck, 7);
    @(negedge tck);

    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 8; c++) run_combo(p, 3'(c));

    // R9: pads hold while shift_en is low (pos 0, no chains)
    pos = 2'd0; cfg_n = 3'b111; rti = 1'b1; tick(); rti = 1'b0;
    tdi = 1'b1; shift_en = 1'b1; tick(); shift_en = 1'b0;
    for (int k = 0; k < 5; k++) begin tdi = k[0]; tick(); end
    chk(tdo == 1'b1, "R9 pads hold without shift", tdo, 1);
    tdi = 1'b0; shift_en = 1'b1; tick(); shift_en = 1'b0;
    chk(tdo == 1'b0, "R9 pad captures with shift", tdo, 0);

    // R10: cfg change without rti has no effect
    cfg_n = 3'b000;
    repeat (4) tick();
    chk(sec_tdo_oe == 3'b000, "R10 cfg ignored outside idle", sec_tdo_oe, 0);
    rti = 1'b1; tms = 1'b1; tick(); rti = 1'b0;
    chk(sec_tdo_oe == 3'b111, "R10 cfg taken in idle", sec_tdo_oe, 7);

    // R4: exclude chains 0 and 2 while tms is low, then raise tms
    tms = 1'b0; cfg_n = 3'b101; rti = 1'b1; tick(); rti = 1'b0;
    tms = 1'b1;
    repeat (3) tick();
    held = sec_tms[0] | sec_tms[2];
    chk(held == 1'b0, "R4 excluded tms frozen low", {sec_tms[2], sec_tms[0]}, 0);
    chk(sec_tms[1] == 1'b1, "R4 included tms follows", sec_tms[1], 1);
    chk(sec_tdo_oe == 3'b010, "R3 excluded outputs released", sec_tdo_oe, 2);

    report();
    $finish;
  end
endmodule